// File: doc/BRIEF.md
# UART enable and status control

This block is the control and status core of an asynchronous serial port. It sits between a simple register bus and the transmit and receive shift engines. It holds the enable, clock-source and interrupt-enable settings, a frame-format byte and a baud divisor. It also keeps the transmit and receive status flags. The block decides when the serial pins belong to the port and when a bit clock is driven out. It hands bytes to the transmit engine and takes bytes from the receive engine through one-cycle pulse handshakes.

Software first programs the divisor and frame format while both enables are off, and only then turns the port on. A transmitter that is switched off reports its data register as empty at once. A receiver that is switched off keeps every flag and the last received byte, so software can still collect them. A receive error stops further reception until software acknowledges it: it reads the status register and then writes a 0 to the error bit.

Register map (3-bit address): 0 control, 1 frame format, 2 divisor, 3 status, 4 data (a write loads transmit data, a read returns received data). Control bits: [0] transmit enable, [1] receive enable, [3:2] clock source (00 internal, 01 internal with clock output, 1x external tick), [4] receive interrupt enable, [5] transmit-empty interrupt enable, [6] transmit-end interrupt enable. Status bits: [0] transmit empty, [1] receive full, [2] parity error, [3] framing error, [4] overrun, [5] transmit end.

Top module: `uart_ctl_status`

## Requirements
- R1: After reset the status register reads 0x21 (transmit empty and transmit end set). The control register reads 0. Both pin-ownership outputs, the clock-output enable and all three interrupt outputs are 0.
- R2: A write to the control register with bit 0 at 0 sets transmit empty and transmit end in the next cycle. A byte that is waiting in the transmit data register is then never handed to the engine.
- R3: A write to the control register with bit 1 at 0 leaves receive full, parity error, framing error, overrun and the received byte unchanged.
- R4: txd_serial equals the transmit enable bit and rxd_serial equals the receive enable bit. While receive enable is 0 a frame pulse is ignored, and tx_start only pulses while the transmitter owns its pin.
- R5: In the cycle after a control write with bits [3:2] = 01, sck_oe is 1. For any other clock source it is 0.
- R6: With an internal clock source, baud_tick pulses once every divisor+1 cycles. With an external source (bits [3:2] = 1x), baud_tick follows ext_clk_tick one cycle later and the divisor has no effect.
- R7: Writes to the format (address 1) or divisor (address 2) register are ignored while either enable is 1.
- R8: An error flag (status bits 2 to 4) clears only when software writes 0 to that bit after a status read that showed the flag set. Writing 1 has no effect, and no other event clears it.
- R9: While any error flag is set, a received frame is dropped: the received byte and receive full stay unchanged.
- R10: A frame that arrives while receive full is set sets overrun and leaves the earlier byte in place.
- R11: A write to address 4 clears transmit empty. The byte is then passed to the engine with tx_start, at which point transmit empty sets and transmit end clears. Transmit end sets again when tx_done arrives and no further byte is waiting.
- R12: irq_rx is receive interrupt enable AND (receive full OR any error flag). irq_tx is its enable AND transmit empty. irq_tend is its enable AND transmit end.
- R13: A bus read of address 4 returns the received byte and clears receive full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read side effects) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| ext_clk_tick | input | 1 | External baud tick pulse |
| baud_tick | output | 1 | Baud tick to the shift engines |
| sck_out | output | 1 | Bit clock driven out on the clock pin |
| sck_oe | output | 1 | Clock pin output enable |
| txd_serial | output | 1 | 1: TxD pin serves the port, 0: general-purpose I/O |
| rxd_serial | output | 1 | 1: RxD pin serves the port, 0: general-purpose I/O |
| tx_start | output | 1 | One-cycle pulse handing tx_byte to the engine |
| tx_byte | output | 8 | Byte being transmitted |
| tx_done | input | 1 | Engine has finished the current frame |
| rx_valid | input | 1 | Engine delivers a received frame |
| rx_byte | input | 8 | Received byte |
| rx_par_err | input | 1 | Parity error of the delivered frame |
| rx_frm_err | input | 1 | Framing error of the delivered frame |
| frame_fmt | output | 8 | Frame-format setting for the engines |
| irq_rx | output | 1 | Receive full or error interrupt |
| irq_tx | output | 1 | Transmit empty interrupt |
| irq_tend | output | 1 | Transmit end interrupt |

## Verification
The bench turns the transmitter off while one byte is on the line and a second byte waits. A design that failed to force transmit empty would later send the stale byte, and the scoreboard would see a start it did not expect. The bench turns the receiver off with receive full and a framing error both pending. It tries to clear an error flag both without a prior status read and by writing 1. It also delivers frames during overrun and during an error. A design that wiped flags on disable, cleared flags too readily, or kept receiving would show wrong status or data on readback. Format and divisor writes made while enabled, and the switch to external ticks, are checked by reading back the registers and counting baud ticks.

// File: rtl/uart_ctl_pkg.sv
package uart_ctl_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [2:0] {
        A_CTRL = 3'd0,
        A_FMT  = 3'd1,
        A_DIV  = 3'd2,
        A_STAT = 3'd3,
        A_DATA = 3'd4
    } reg_addr_e;

    typedef enum logic [1:0] {
        TX_OFF  = 2'd0,
        TX_IDLE = 2'd1,
        TX_BUSY = 2'd2
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_OFF     = 2'd0,
        RX_LISTEN  = 2'd1,
        RX_BLOCKED = 2'd2
    } rx_state_e;

    // control register layout, LSB first: tx_en, rx_en, clk_sel, irq enables
    typedef struct packed {
        logic       tend_ie;
        logic       tx_ie;
        logic       rx_ie;
        logic [1:0] clk_sel;
        logic       rx_en;
        logic       tx_en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam logic [1:0] CLK_INT_OUT = 2'b01;

    // status bit positions
    localparam int ST_TDRE = 0;
    localparam int ST_RDRF = 1;
    localparam int ST_PER  = 2;
    localparam int ST_FER  = 3;
    localparam int ST_ORER = 4;
    localparam int ST_TEND = 5;
    localparam int N_ERR   = 3;

endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_sel,
    input  logic [DIV_W-1:0] div,
    input  logic             ext_tick,
    output logic             baud_tick,
    output logic             sck_phase
);

    logic [DIV_W-1:0] cnt_q;
    logic             tick_q;
    logic             phase_q;
    logic             wrap;

    assign wrap = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            tick_q  <= 1'b0;
            phase_q <= 1'b0;
        end else if (ext_sel) begin
            // counter parked on the divisor while the external tick rules
            cnt_q   <= div;
            tick_q  <= ext_tick;
        end else begin
            tick_q <= wrap;
            if (wrap) begin
                cnt_q   <= div;
                phase_q <= ~phase_q;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign baud_tick = tick_q;
    assign sck_phase = phase_q;

endmodule

// File: rtl/uart_tx_ctl.sv
module uart_tx_ctl
    import uart_ctl_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              tx_dis,
    input  logic              tdr_wr,
    input  logic [DATA_W-1:0] tdr_in,
    input  logic              tx_done,
    output logic              tdre,
    output logic              tend,
    output logic              tx_start,
    output logic [DATA_W-1:0] tx_byte
);

    tx_state_e         state_q, state_d;
    logic              launch;
    logic              finish;
    logic              en_eff;
    logic [DATA_W-1:0] tdr_q;
    logic              tdre_q, tend_q;
    logic              start_q;
    logic [DATA_W-1:0] byte_q;

    // a disabling control write takes effect in the same cycle
    assign en_eff = tx_en && !tx_dis;

    always_comb begin
        state_d = state_q;
        launch  = 1'b0;
        finish  = 1'b0;
        unique case (state_q)
            TX_OFF: begin
                if (en_eff) state_d = TX_IDLE;
            end
            TX_IDLE: begin
                if (!en_eff) begin
                    state_d = TX_OFF;
                end else if (!tdre_q) begin
                    launch  = 1'b1;
                    state_d = TX_BUSY;
                end
            end
            TX_BUSY: begin
                if (!en_eff) begin
                    state_d = TX_OFF;
                end else if (tx_done) begin
                    if (!tdre_q) begin
                        launch = 1'b1;
                    end else begin
                        finish  = 1'b1;
                        state_d = TX_IDLE;
                    end
                end
            end
            default: state_d = TX_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tdr_q   <= '0;
            tdre_q  <= 1'b1;
            tend_q  <= 1'b1;
            start_q <= 1'b0;
            byte_q  <= '0;
        end else begin
            start_q <= launch;
            if (launch) byte_q <= tdr_q;
            if (tdr_wr) tdr_q <= tdr_in;

            if (tx_dis)      tdre_q <= 1'b1;
            else if (tdr_wr) tdre_q <= 1'b0;
            else if (launch) tdre_q <= 1'b1;

            if (tx_dis)      tend_q <= 1'b1;
            else if (launch) tend_q <= 1'b0;
            else if (finish) tend_q <= 1'b1;
        end
    end

    assign tdre     = tdre_q;
    assign tend     = tend_q;
    assign tx_start = start_q;
    assign tx_byte  = byte_q;

endmodule

// File: rtl/uart_rx_ctl.sv
module uart_rx_ctl
    import uart_ctl_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_par_err,
    input  logic              rx_frm_err,
    input  logic              rdr_pop,
    input  logic [N_ERR-1:0]  err_clr,
    output logic              rdrf,
    output logic [N_ERR-1:0]  err,
    output logic [DATA_W-1:0] rdr
);

    // err vector: [0] parity, [1] framing, [2] overrun
    rx_state_e         state_q, state_d;
    logic              rdrf_q, rdrf_d;
    logic [N_ERR-1:0]  err_q, err_d;
    logic [DATA_W-1:0] rdr_q;
    logic              take;
    logic              listening;

    assign listening = (state_q == RX_LISTEN) && rx_en;

    always_comb begin
        rdrf_d = rdrf_q;
        err_d  = err_q & ~err_clr;
        take   = 1'b0;
        if (rdr_pop) rdrf_d = 1'b0;
        if (listening && rx_valid) begin
            if (rdrf_q) begin
                err_d[2] = 1'b1;
            end else begin
                take     = 1'b1;
                rdrf_d   = 1'b1;
                err_d[0] = err_d[0] | rx_par_err;
                err_d[1] = err_d[1] | rx_frm_err;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_OFF: begin
                if (rx_en) state_d = (|err_d) ? RX_BLOCKED : RX_LISTEN;
            end
            RX_LISTEN: begin
                if (!rx_en)      state_d = RX_OFF;
                else if (|err_d) state_d = RX_BLOCKED;
            end
            RX_BLOCKED: begin
                if (!rx_en)         state_d = RX_OFF;
                else if (!(|err_d)) state_d = RX_LISTEN;
            end
            default: state_d = RX_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RX_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdrf_q <= 1'b0;
            err_q  <= '0;
            rdr_q  <= '0;
        end else begin
            rdrf_q <= rdrf_d;
            err_q  <= err_d;
            if (take) rdr_q <= rx_byte;
        end
    end

    assign rdrf = rdrf_q;
    assign err  = err_q;
    assign rdr  = rdr_q;

endmodule

// File: rtl/uart_ctl_status.sv
module uart_ctl_status
    import uart_ctl_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ext_clk_tick,
    output logic              baud_tick,
    output logic              sck_out,
    output logic              sck_oe,
    output logic              txd_serial,
    output logic              rxd_serial,
    output logic              tx_start,
    output logic [DATA_W-1:0] tx_byte,
    input  logic              tx_done,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_par_err,
    input  logic              rx_frm_err,
    output logic [DATA_W-1:0] frame_fmt,
    output logic              irq_rx,
    output logic              irq_tx,
    output logic              irq_tend
);

    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] fmt_q;
    logic [DATA_W-1:0] div_q;
    logic [N_ERR-1:0]  err_arm_q;

    logic wr_ctrl, wr_fmt, wr_div, wr_stat, wr_data;
    logic rd_stat, rd_data;
    logic locked, tx_dis;

    logic              tdre_w, tend_w, rdrf_w;
    logic [N_ERR-1:0]  rx_err_w;
    logic [N_ERR-1:0]  err_clr;
    logic [DATA_W-1:0] rdr_w;
    logic [DATA_W-1:0] status_w;
    logic              sck_phase;

    // bus decode
    assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    assign wr_fmt  = bus_wr && (bus_addr == A_FMT);
    assign wr_div  = bus_wr && (bus_addr == A_DIV);
    assign wr_stat = bus_wr && (bus_addr == A_STAT);
    assign wr_data = bus_wr && (bus_addr == A_DATA);
    assign rd_stat = bus_rd && (bus_addr == A_STAT);
    assign rd_data = bus_rd && (bus_addr == A_DATA);

    assign locked  = ctrl_q.tx_en || ctrl_q.rx_en;
    assign tx_dis  = wr_ctrl && !bus_wdata[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            fmt_q  <= '0;
            div_q  <= '0;
        end else begin
            if (wr_ctrl)           ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            if (wr_fmt && !locked) fmt_q  <= bus_wdata;
            if (wr_div && !locked) div_q  <= bus_wdata;
        end
    end

    // error acknowledge: a status read arms each flag it saw set,
    // a later write of 0 to an armed flag clears it
    assign err_clr = {N_ERR{wr_stat}} & err_arm_q & ~bus_wdata[ST_ORER:ST_PER];

    always_ff @(posedge clk) begin
        if (!rst_n) err_arm_q <= '0;
        else        err_arm_q <= (err_arm_q & ~err_clr) | ({N_ERR{rd_stat}} & rx_err_w);
    end

    uart_baud_gen #(.DIV_W(DATA_W)) u_baud (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_sel   (ctrl_q.clk_sel[1]),
        .div       (div_q),
        .ext_tick  (ext_clk_tick),
        .baud_tick (baud_tick),
        .sck_phase (sck_phase)
    );

    uart_tx_ctl #(.DATA_W(DATA_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_en    (ctrl_q.tx_en),
        .tx_dis   (tx_dis),
        .tdr_wr   (wr_data),
        .tdr_in   (bus_wdata),
        .tx_done  (tx_done),
        .tdre     (tdre_w),
        .tend     (tend_w),
        .tx_start (tx_start),
        .tx_byte  (tx_byte)
    );

    uart_rx_ctl #(.DATA_W(DATA_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_en      (ctrl_q.rx_en),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .rx_par_err (rx_par_err),
        .rx_frm_err (rx_frm_err),
        .rdr_pop    (rd_data),
        .err_clr    (err_clr),
        .rdrf       (rdrf_w),
        .err        (rx_err_w),
        .rdr        (rdr_w)
    );

    assign status_w = DATA_W'({tend_w, rx_err_w, rdrf_w, tdre_w});

    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = DATA_W'(ctrl_q);
            A_FMT:   bus_rdata = fmt_q;
            A_DIV:   bus_rdata = div_q;
            A_STAT:  bus_rdata = status_w;
            A_DATA:  bus_rdata = rdr_w;
            default: bus_rdata = '0;
        endcase
    end

    assign sck_oe     = (ctrl_q.clk_sel == CLK_INT_OUT);
    assign sck_out    = sck_oe && sck_phase;
    assign txd_serial = ctrl_q.tx_en;
    assign rxd_serial = ctrl_q.rx_en;
    assign frame_fmt  = fmt_q;

    assign irq_rx   = ctrl_q.rx_ie   && (rdrf_w || (|rx_err_w));
    assign irq_tx   = ctrl_q.tx_ie   && tdre_w;
    assign irq_tend = ctrl_q.tend_ie && tend_w;

endmodule

// File: rtl/uart_ctl_status_chk.sv
module uart_ctl_status_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [2:0]        bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              rx_valid,
    input logic              txd_serial,
    input logic              rxd_serial,
    input logic              tx_start,
    input logic              sck_oe,
    input logic              tdre,
    input logic              rdrf,
    input logic [2:0]        rx_err,
    input logic [DATA_W-1:0] rdr,
    input logic [DATA_W-1:0] fmt,
    input logic [DATA_W-1:0] div
);

    assert_tdre_on_disable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd0 && !bus_wdata[0]) |=> tdre);

    assert_rx_off_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd0 && !bus_wdata[1] && !bus_rd && !rx_valid)
        |=> ($stable(rdrf) && $stable(rx_err) && $stable(rdr)));

    assert_tx_pin_owned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> txd_serial);

    assert_sck_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd0 && bus_wdata[3:2] == 2'b01) |=> sck_oe);

    assert_fmt_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd1 && (txd_serial || rxd_serial)) |=> $stable(fmt));

    assert_div_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd2 && (txd_serial || rxd_serial)) |=> $stable(div));

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ((rx_err & $past(rx_err)) == $past(rx_err)));

    assert_blocked_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((|rx_err) && rx_valid && !bus_wr) |=> $stable(rdr));

endmodule

bind uart_ctl_status uart_ctl_status_chk #(.DATA_W(DATA_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .rx_valid   (rx_valid),
    .txd_serial (txd_serial),
    .rxd_serial (rxd_serial),
    .tx_start   (tx_start),
    .sck_oe     (sck_oe),
    .tdre       (tdre_w),
    .rdrf       (rdrf_w),
    .rx_err     (rx_err_w),
    .rdr        (rdr_w),
    .fmt        (fmt_q),
    .div        (div_q)
);

// File: tb/test_uart_ctl_status.sv
module test_uart_ctl_status;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic       ext_clk_tick = 1'b0, baud_tick, sck_out, sck_oe;
    logic       txd_serial, rxd_serial, tx_start, tx_done = 1'b0;
    logic [7:0] tx_byte, frame_fmt;
    logic       rx_valid = 1'b0, rx_par_err = 1'b0, rx_frm_err = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       irq_rx, irq_tx, irq_tend;

    int n_checks = 0;
    int n_err    = 0;
    logic [7:0] exp_tx[$];
    int busy_cnt = 0;
    logic [7:0] rd;

    always #2 clk = ~clk;

    uart_ctl_status i_uart_ctl_status (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_clk_tick(ext_clk_tick), .baud_tick(baud_tick), .sck_out(sck_out),
        .sck_oe(sck_oe), .txd_serial(txd_serial), .rxd_serial(rxd_serial),
        .tx_start(tx_start), .tx_byte(tx_byte), .tx_done(tx_done),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_par_err(rx_par_err),
        .rx_frm_err(rx_frm_err), .frame_fmt(frame_fmt),
        .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_tend(irq_tend)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // driver: expected byte goes to the scoreboard, then into the data register
    task automatic send_tx(input logic [7:0] b);
        exp_tx.push_back(b);
        bus_write(3'd4, b);
    endtask

    task automatic rx_frame(input logic [7:0] b, input logic pe, input logic fe);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b; rx_par_err = pe; rx_frm_err = fe;
        @(negedge clk);
        rx_valid = 1'b0; rx_par_err = 1'b0; rx_frm_err = 1'b0;
    endtask

    // monitor and stub transmit engine
    always @(negedge clk) begin
        tx_done = (busy_cnt == 1);
        if (busy_cnt > 0) busy_cnt--;
        if (tx_start) begin
            busy_cnt = 12;
            n_checks++;
            if (exp_tx.size() == 0) begin
                n_err++;
                $display("FAIL R11: actual start of %h expected no start", tx_byte);
            end else begin
                logic [7:0] e;
                e = exp_tx.pop_front();
                if (tx_byte !== e) begin
                    n_err++;
                    $display("FAIL R11: actual %h expected %h", tx_byte, e);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        int c;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(3'd3, rd); check("R1 status", rd, 8'h21);
        bus_read(3'd0, rd); check("R1 control", rd, 8'h00);
        check("R1 pins/clock", {txd_serial, rxd_serial, sck_oe}, 8'h00);
        check("R1 irqs", {irq_rx, irq_tx, irq_tend}, 8'h00);

        // R6 internal baud from divisor 3 -> period 4
        bus_write(3'd2, 8'd3);
        bus_write(3'd1, 8'h05);
        repeat (10) @(negedge clk);
        c = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); if (baud_tick) c++; end
        check("R6 internal ticks", 8'(c), 8'd10);

        // enable everything, clock output selected
        bus_write(3'd0, 8'h77);
        check("R5 sck_oe", {7'd0, sck_oe}, 8'h01);
        check("R4 pins owned", {txd_serial, rxd_serial}, 8'h03);
        check("R12 irqs idle", {irq_rx, irq_tx, irq_tend}, 8'h03);

        // R7 locked registers
        bus_write(3'd1, 8'hAA);
        bus_write(3'd2, 8'h09);
        bus_read(3'd1, rd); check("R7 fmt locked", rd, 8'h05);
        bus_read(3'd2, rd); check("R7 div locked", rd, 8'h03);

        // R11 transmit
        send_tx(8'h3C);
        repeat (30) @(negedge clk);
        bus_read(3'd3, rd); check("R11 idle after one", rd & 8'h21, 8'h21);
        send_tx(8'h81);
        send_tx(8'h42);
        bus_read(3'd3, rd); check("R11 busy with pending", rd & 8'h21, 8'h00);
        check("R12 irq_tx off", {7'd0, irq_tx}, 8'h00);
        repeat (40) @(negedge clk);
        bus_read(3'd3, rd); check("R11 all sent", rd & 8'h21, 8'h21);

        // R2 disable drops pending byte
        send_tx(8'h11);
        @(negedge clk);
        bus_write(3'd4, 8'h99);
        bus_read(3'd3, rd); check("R2 pending", rd & 8'h01, 8'h00);
        bus_write(3'd0, 8'h76);
        check("R4 txd released", {7'd0, txd_serial}, 8'h00);
        bus_read(3'd3, rd); check("R2 empty forced", rd & 8'h21, 8'h21);
        bus_write(3'd0, 8'h77);
        repeat (30) @(negedge clk);

        // R13 receive
        rx_frame(8'h5A, 1'b0, 1'b0);
        bus_read(3'd3, rd); check("R13 full", rd, 8'h23);
        check("R12 irq_rx", {7'd0, irq_rx}, 8'h01);
        bus_read(3'd4, rd); check("R13 data", rd, 8'h5A);
        bus_read(3'd3, rd); check("R13 full cleared", rd, 8'h21);

        // R10 overrun, R9 blocked
        rx_frame(8'h01, 1'b0, 1'b0);
        rx_frame(8'h02, 1'b0, 1'b0);
        bus_read(3'd3, rd); check("R10 overrun", rd, 8'h33);
        bus_read(3'd4, rd); check("R10 first kept", rd, 8'h01);
        rx_frame(8'h03, 1'b0, 1'b0);
        bus_read(3'd3, rd); check("R9 dropped status", rd, 8'h31);
        bus_read(3'd4, rd); check("R9 dropped data", rd, 8'h01);
        bus_write(3'd3, 8'h00);
        bus_read(3'd3, rd); check("R8 overrun cleared", rd, 8'h21);

        // R8 acknowledge rules
        rx_frame(8'h44, 1'b1, 1'b0);
        bus_write(3'd3, 8'h00);
        bus_read(3'd3, rd); check("R8 unarmed write", rd, 8'h27);
        bus_write(3'd3, 8'hFF);
        bus_read(3'd3, rd); check("R8 write one", rd, 8'h27);
        bus_write(3'd3, 8'h00);
        bus_read(3'd3, rd); check("R8 armed clear", rd, 8'h23);
        bus_read(3'd4, rd); check("R8 data", rd, 8'h44);

        // R3 receiver off keeps state, R4 frames ignored
        rx_frame(8'h77, 1'b0, 1'b1);
        bus_write(3'd0, 8'h75);
        check("R4 rxd released", {7'd0, rxd_serial}, 8'h00);
        bus_read(3'd3, rd); check("R3 flags kept", rd, 8'h2B);
        bus_read(3'd4, rd); check("R3 data kept", rd, 8'h77);
        bus_write(3'd3, 8'h00);
        rx_frame(8'h12, 1'b0, 1'b0);
        bus_read(3'd3, rd); check("R4 frame ignored status", rd, 8'h21);
        bus_read(3'd4, rd); check("R4 frame ignored data", rd, 8'h77);

        // R6 external clock, R5 off, R12 gating
        bus_write(3'd0, 8'h08);
        check("R5 no clock out", {7'd0, sck_oe}, 8'h00);
        check("R12 gated", {irq_rx, irq_tx, irq_tend}, 8'h00);
        c = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (baud_tick) c++;
            ext_clk_tick = (i % 5 == 0) && (i < 35);
        end
        check("R6 external ticks", 8'(c), 8'd7);

        check("R11 scoreboard drained", 8'(exp_tx.size()), 8'd0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule